// File: doc/BRIEF.md
# Multiplexed-Bus Burst Write Sequencer

This block runs one synchronous multi-beat write to an external 16-bit memory whose address and data share a single bus, with the address sent in two phases. A start request latches a word address, a burst length of 1 to 8 beats and a full set of timing counts. From then on an access counter steps once per clock, and each active-low strobe is placed by its own pair of counts. The strobes are chip select, address valid, write enable, an output-enable line that marks the first address phase, and two byte enables. The shared bus first carries the upper address bits, then the lower address bits, and finally the data beats. A direction output points external transceivers toward the memory for the whole access.

Once the counter reaches the write access time and beats remain, the counter and every strobe level freeze. Each further beat is then shown for one page-burst period, and the counter resumes after the last beat. The access ends at the write cycle time plus the freeze, and the block then raises a one-cycle done pulse with all strobes inactive. Write beats come in through a ready/valid handshake. While the block waits for a beat that is not yet valid, everything it drives holds still.

Counts are in clock cycles from the access start. All outputs are registered, so the value for access count c shows on the pins one cycle after the counter holds c. The timing set must satisfy lower-address end <= data-on < access time < cycle time.

Top module: `aad_burst_wr`

## Requirements
- R1: Out of reset and while idle: cs_n_o, adv_n_o, we_n_o and oe_n_o are 1, be_n_o is 2'b11, ad_o is 0, and dir_o, done_o, wready_o and busy_o are 0.
- R2: With the start sampled at clock edge E0, the outputs after edge E0+1+k show access count c. Without freeze or stall, c = k. cs_n_o is 0 exactly when cs_on_i <= c < cs_off_i.
- R3: adv_n_o is 0 exactly when adv_on_i <= c < adv_off_i.
- R4: we_n_o is 0 exactly when we_on_i <= c < we_off_i.
- R5: oe_n_o is 0 exactly when oe_on_i <= c < oe_off_i. ad_o carries address bits [26:16], zero-extended, while c < oe_off_i. It carries address bits [15:0] while oe_off_i <= c < data_on_i.
- R6: From c = data_on_i on, ad_o carries the current beat word and be_n_o carries the inverse of that beat's wstrb_i. Beat 0 is shown while data_on_i <= c <= acc_time_i.
- R7: For a burst of L > 1 beats, count acc_time_i is held for F = P*(L-1) further cycles, where P = page_time_i, or 1 when page_time_i is 0. In that time all strobes stay stable and beat j (j >= 1) is shown for P cycles. Afterward c = k - F and the last beat stays on the bus.
- R8: A burst of 1 beat has no freeze, and done_o rises after edge E0+1+cyc_time_i.
- R9: done_o is 1 for exactly one cycle, after edge E0+1+cyc_time_i+F(+stall). In that cycle all strobes are 1 and dir_o is 0. done_o is 0 during the access.
- R10: dir_o is 1 (out) on every cycle that shows an access count.
- R11: A start_i while busy_o is 1 is ignored: the running access keeps its address, and no second access follows it.
- R12: wready_o is 1 while a beat is needed (at c = data_on_i and at the start of each page period). A beat is taken only when wvalid_i is also 1. While wready_o is 1 and wvalid_i is 0, all outputs hold. Exactly L beats are taken per burst.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Access request, sampled while idle |
| addr_i | input | 27 | Word address (byte address bits 27:1) |
| blen_i | input | 3 | Burst length minus one |
| cs_on_i | input | 4 | Chip-select assert count |
| cs_off_i | input | 5 | Chip-select release count |
| adv_on_i | input | 4 | Address-valid assert count |
| adv_off_i | input | 5 | Address-valid release count |
| we_on_i | input | 4 | Write-enable assert count |
| we_off_i | input | 5 | Write-enable release count |
| oe_on_i | input | 4 | First-address-phase marker assert count |
| oe_off_i | input | 4 | First-address-phase marker release count |
| data_on_i | input | 4 | Count at which beat 0 reaches the bus |
| acc_time_i | input | 5 | Write access time count |
| page_time_i | input | 4 | Cycles per further beat |
| cyc_time_i | input | 5 | Write cycle time count |
| wdata_i | input | 16 | Write beat word |
| wstrb_i | input | 2 | Byte strobes of the beat |
| wvalid_i | input | 1 | Beat valid |
| wready_o | output | 1 | Beat taken when valid |
| busy_o | output | 1 | Access in progress |
| cs_n_o | output | 1 | Chip select, active low |
| adv_n_o | output | 1 | Address valid, active low |
| we_n_o | output | 1 | Write enable, active low |
| oe_n_o | output | 1 | First-address-phase marker, active low |
| be_n_o | output | 2 | Byte enables, active low |
| ad_o | output | 16 | Shared address/data bus |
| dir_o | output | 1 | Transceiver direction, 1 = out |
| done_o | output | 1 | One-cycle end-of-access pulse |

## Verification
Each output is registered behind the access counter, so the bench samples on the falling edge after edge E0+1+k and maps k to the access count. For each sample it subtracts any stall cycles counted from data-on, maps the freeze window to the held access time and the current beat, and then compares every strobe, the bus and the byte enables against that count. done_o is due one cycle after the last count, cyc_time_i+F+stall+1 edges after the start. wready_o is due in the same cycle as the counter reaches data-on, and it is checked there under a held-low valid.

// File: rtl/mbw_pkg.sv
package mbw_pkg;
  localparam int ON_W  = 4;
  localparam int OFF_W = 5;
  localparam int CNT_W = 5;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RUN  = 2'd1,
    ST_TAIL = 2'd2
  } seq_st_e;

  typedef struct packed {
    logic [ON_W-1:0]  cs_on;
    logic [OFF_W-1:0] cs_off;
    logic [ON_W-1:0]  adv_on;
    logic [OFF_W-1:0] adv_off;
    logic [ON_W-1:0]  we_on;
    logic [OFF_W-1:0] we_off;
    logic [ON_W-1:0]  oe_on;
    logic [ON_W-1:0]  oe_off;
    logic [ON_W-1:0]  data_on;
    logic [OFF_W-1:0] acc;
    logic [ON_W-1:0]  page;
    logic [OFF_W-1:0] cyc;
  } tim_t;
endpackage

// File: rtl/mbw_seq_core.sv
module mbw_seq_core
  import mbw_pkg::*;
#(
  parameter int AW    = 27,
  parameter int LEN_W = 3
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 start_i,
  input  logic [AW-1:0]        addr_i,
  input  logic [LEN_W-1:0]     blen_i,
  input  tim_t                 tim_i,
  input  logic                 wvalid_i,
  output logic                 busy_o,
  output logic                 act_o,
  output logic [CNT_W-1:0]     cnt_o,
  output logic                 frz_o,
  output logic                 ready_o,
  output logic                 fire_o,
  output logic                 stall_o,
  output logic                 done_o,
  output tim_t                 tim_o,
  output logic [AW-1:0]        addr_o
);
  localparam int REM_W = LEN_W + 1;

  seq_st_e          st_q;
  tim_t             tim_q;
  logic [AW-1:0]    addr_q;
  logic [CNT_W-1:0] cnt_q;
  logic [ON_W-1:0]  pg_q;
  logic [REM_W-1:0] rem_q;
  logic             frz_q;
  logic             done_q;

  logic             run;
  logic [ON_W-1:0]  page_eff;
  logic             last_pg;
  logic             at_acc;
  logic             at_end;
  logic [REM_W-1:0] rem_nx;

  assign run      = (st_q == ST_RUN);
  assign page_eff = (tim_q.page == '0) ? ON_W'(1) : tim_q.page;
  assign last_pg  = (pg_q == ON_W'(page_eff - ON_W'(1)));
  assign at_acc   = (cnt_q == tim_q.acc);
  assign at_end   = (cnt_q == CNT_W'(tim_q.cyc - CNT_W'(1)));

  // beat needed: first one at data-on, later ones at each page-period start
  assign ready_o = run && ((!frz_q && cnt_q == CNT_W'(tim_q.data_on)) ||
                           (frz_q && pg_q == '0));
  assign fire_o  = ready_o && wvalid_i;
  assign stall_o = ready_o && !wvalid_i;
  assign rem_nx  = fire_o ? REM_W'(rem_q - REM_W'(1)) : rem_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= ST_IDLE;
      tim_q  <= '0;
      addr_q <= '0;
      cnt_q  <= '0;
      pg_q   <= '0;
      rem_q  <= '0;
      frz_q  <= 1'b0;
      done_q <= 1'b0;
    end else begin
      done_q <= (st_q == ST_TAIL);
      unique case (st_q)
        ST_IDLE: begin
          if (start_i) begin
            st_q   <= ST_RUN;
            tim_q  <= tim_i;
            addr_q <= addr_i;
            cnt_q  <= '0;
            pg_q   <= '0;
            frz_q  <= 1'b0;
            rem_q  <= REM_W'({1'b0, blen_i}) + REM_W'(1);
          end
        end
        ST_RUN: begin
          if (!stall_o) begin
            rem_q <= rem_nx;
            if (!frz_q) begin
              if (at_acc && rem_q != '0) begin
                frz_q <= 1'b1;
                pg_q  <= '0;
              end else if (at_end) begin
                st_q <= ST_TAIL;
              end else begin
                cnt_q <= cnt_q + CNT_W'(1);
              end
            end else if (last_pg) begin
              pg_q <= '0;
              if (rem_nx == '0) begin
                frz_q <= 1'b0;
                if (at_end) st_q <= ST_TAIL;
                else        cnt_q <= cnt_q + CNT_W'(1);
              end
            end else begin
              pg_q <= pg_q + ON_W'(1);
            end
          end
        end
        ST_TAIL: st_q <= ST_IDLE;
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  assign busy_o = (st_q != ST_IDLE);
  assign act_o  = run;
  assign cnt_o  = cnt_q;
  assign frz_o  = frz_q;
  assign done_o = done_q;
  assign tim_o  = tim_q;
  assign addr_o = addr_q;

  // R11
  busy_addr_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && start_i) |=> $stable(addr_q));

endmodule

// File: rtl/mbw_strobe.sv
module mbw_strobe
  import mbw_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic             act_i,
  input  logic [CNT_W-1:0] cnt_i,
  input  logic [CNT_W-1:0] on_i,
  input  logic [CNT_W-1:0] off_i,
  output logic             strb_n_o
);
  logic in_win;

  assign in_win = act_i && (cnt_i >= on_i) && (cnt_i < off_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   strb_n_o <= 1'b1;
    else if (en_i) strb_n_o <= !in_win;
  end
endmodule

// File: rtl/mbw_bus_drv.sv
module mbw_bus_drv
  import mbw_pkg::*;
#(
  parameter int AW = 27,
  parameter int DW = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic             act_i,
  input  logic [CNT_W-1:0] cnt_i,
  input  logic [ON_W-1:0]  oe_off_i,
  input  logic [ON_W-1:0]  data_on_i,
  input  logic [AW-1:0]    addr_i,
  input  logic             fire_i,
  input  logic [DW-1:0]    wdata_i,
  input  logic [1:0]       wstrb_i,
  output logic [DW-1:0]    ad_o,
  output logic [1:0]       be_n_o,
  output logic             dir_o
);
  localparam int HI_W  = AW - DW;
  localparam int PAD_W = DW - HI_W;

  logic [DW-1:0] beat_q;
  logic [1:0]    bstrb_q;
  logic [DW-1:0] cur_w;
  logic [1:0]    cur_s;
  logic [DW-1:0] ad_nx;
  logic [1:0]    be_nx;

  assign cur_w = fire_i ? wdata_i : beat_q;
  assign cur_s = fire_i ? wstrb_i : bstrb_q;

  always_comb begin
    ad_nx = '0;
    be_nx = 2'b11;
    if (act_i) begin
      if (cnt_i < CNT_W'(oe_off_i)) begin
        ad_nx = {{PAD_W{1'b0}}, addr_i[AW-1:DW]};
      end else if (cnt_i < CNT_W'(data_on_i)) begin
        ad_nx = addr_i[DW-1:0];
      end else begin
        ad_nx = cur_w;
        be_nx = ~cur_s;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      beat_q  <= '0;
      bstrb_q <= '0;
      ad_o    <= '0;
      be_n_o  <= 2'b11;
      dir_o   <= 1'b0;
    end else if (en_i) begin
      if (fire_i) begin
        beat_q  <= wdata_i;
        bstrb_q <= wstrb_i;
      end
      ad_o   <= ad_nx;
      be_n_o <= be_nx;
      dir_o  <= act_i;
    end
  end
endmodule

// File: rtl/aad_burst_wr.sv
module aad_burst_wr
  import mbw_pkg::*;
#(
  parameter int AW    = 27,
  parameter int DW    = 16,
  parameter int LEN_W = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic [AW-1:0]    addr_i,
  input  logic [LEN_W-1:0] blen_i,
  input  logic [3:0]       cs_on_i,
  input  logic [4:0]       cs_off_i,
  input  logic [3:0]       adv_on_i,
  input  logic [4:0]       adv_off_i,
  input  logic [3:0]       we_on_i,
  input  logic [4:0]       we_off_i,
  input  logic [3:0]       oe_on_i,
  input  logic [3:0]       oe_off_i,
  input  logic [3:0]       data_on_i,
  input  logic [4:0]       acc_time_i,
  input  logic [3:0]       page_time_i,
  input  logic [4:0]       cyc_time_i,
  input  logic [DW-1:0]    wdata_i,
  input  logic [1:0]       wstrb_i,
  input  logic             wvalid_i,
  output logic             wready_o,
  output logic             busy_o,
  output logic             cs_n_o,
  output logic             adv_n_o,
  output logic             we_n_o,
  output logic             oe_n_o,
  output logic [1:0]       be_n_o,
  output logic [DW-1:0]    ad_o,
  output logic             dir_o,
  output logic             done_o
);
  localparam int NSTB = 4;

  tim_t             tim_in;
  tim_t             tim;
  logic [AW-1:0]    addr_q;
  logic             act;
  logic [CNT_W-1:0] cnt;
  logic             frz;
  logic             fire;
  logic             stall;
  logic             en;
  logic [CNT_W-1:0] on_v  [NSTB];
  logic [CNT_W-1:0] off_v [NSTB];
  logic [NSTB-1:0]  sn;

  assign tim_in = '{cs_on: cs_on_i, cs_off: cs_off_i, adv_on: adv_on_i,
                    adv_off: adv_off_i, we_on: we_on_i, we_off: we_off_i,
                    oe_on: oe_on_i, oe_off: oe_off_i, data_on: data_on_i,
                    acc: acc_time_i, page: page_time_i, cyc: cyc_time_i};

  mbw_seq_core #(.AW(AW), .LEN_W(LEN_W)) u_core (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .start_i  (start_i),
    .addr_i   (addr_i),
    .blen_i   (blen_i),
    .tim_i    (tim_in),
    .wvalid_i (wvalid_i),
    .busy_o   (busy_o),
    .act_o    (act),
    .cnt_o    (cnt),
    .frz_o    (frz),
    .ready_o  (wready_o),
    .fire_o   (fire),
    .stall_o  (stall),
    .done_o   (done_o),
    .tim_o    (tim),
    .addr_o   (addr_q)
  );

  assign en = !stall;

  // strobe order: cs, adv, we, oe
  assign on_v[0]  = CNT_W'(tim.cs_on);
  assign off_v[0] = tim.cs_off;
  assign on_v[1]  = CNT_W'(tim.adv_on);
  assign off_v[1] = tim.adv_off;
  assign on_v[2]  = CNT_W'(tim.we_on);
  assign off_v[2] = tim.we_off;
  assign on_v[3]  = CNT_W'(tim.oe_on);
  assign off_v[3] = CNT_W'(tim.oe_off);

  for (genvar g = 0; g < NSTB; g++) begin : g_stb
    mbw_strobe u_stb (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .en_i     (en),
      .act_i    (act),
      .cnt_i    (cnt),
      .on_i     (on_v[g]),
      .off_i    (off_v[g]),
      .strb_n_o (sn[g])
    );
  end

  assign cs_n_o  = sn[0];
  assign adv_n_o = sn[1];
  assign we_n_o  = sn[2];
  assign oe_n_o  = sn[3];

  mbw_bus_drv #(.AW(AW), .DW(DW)) u_bus (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .en_i      (en),
    .act_i     (act),
    .cnt_i     (cnt),
    .oe_off_i  (tim.oe_off),
    .data_on_i (tim.data_on),
    .addr_i    (addr_q),
    .fire_i    (fire),
    .wdata_i   (wdata_i),
    .wstrb_i   (wstrb_i),
    .ad_o      (ad_o),
    .be_n_o    (be_n_o),
    .dir_o     (dir_o)
  );

  // R7
  frozen_strobe_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (frz && $past(frz)) |=> $stable({cs_n_o, adv_n_o, we_n_o, oe_n_o}));

  // R9
  done_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (cs_n_o && adv_n_o && we_n_o && oe_n_o && !dir_o));

  // R9
  done_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  // R10
  cs_dir_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cs_n_o |-> dir_o);

  // R12
  ready_busy_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wready_o |-> busy_o);

endmodule

// File: tb/aad_burst_wr_bench.sv
module aad_burst_wr_bench;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [26:0] addr = '0;
  logic [2:0]  blen = '0;
  logic [3:0]  cs_on, adv_on, we_on, oe_on, oe_off, data_on, page;
  logic [4:0]  cs_off, adv_off, we_off, acc, cyc;
  logic [15:0] wdata;
  logic [1:0]  wstrb;
  logic        wvalid = 1'b1;
  logic        wready, busy, cs_n, adv_n, we_n, oe_n, dir, done;
  logic [1:0]  be_n;
  logic [15:0] ad;

  int errors = 0;
  int checks = 0;
  int beats_total = 0;
  bit wd_hit = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [15:0] word_fn(int x);
    return 16'hA500 ^ 16'(x * 305);
  endfunction
  function automatic logic [1:0] strb_fn(int x);
    return 2'(x) ^ 2'b01;
  endfunction

  always @(posedge clk) if (wvalid && wready) beats_total <= beats_total + 1;
  assign wdata = word_fn(beats_total);
  assign wstrb = strb_fn(beats_total);

  aad_burst_wr u_aad_burst_wr (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .addr_i(addr), .blen_i(blen),
    .cs_on_i(cs_on), .cs_off_i(cs_off), .adv_on_i(adv_on), .adv_off_i(adv_off),
    .we_on_i(we_on), .we_off_i(we_off), .oe_on_i(oe_on), .oe_off_i(oe_off),
    .data_on_i(data_on), .acc_time_i(acc), .page_time_i(page), .cyc_time_i(cyc),
    .wdata_i(wdata), .wstrb_i(wstrb), .wvalid_i(wvalid), .wready_o(wready),
    .busy_o(busy), .cs_n_o(cs_n), .adv_n_o(adv_n), .we_n_o(we_n), .oe_n_o(oe_n),
    .be_n_o(be_n), .ad_o(ad), .dir_o(dir), .done_o(done)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic set_tim(input int a_cs_on, a_cs_off, a_adv_on, a_adv_off,
                         a_we_on, a_we_off, a_oe_on, a_oe_off, a_data_on,
                         a_acc, a_page, a_cyc);
    cs_on = 4'(a_cs_on);   cs_off = 5'(a_cs_off);
    adv_on = 4'(a_adv_on); adv_off = 5'(a_adv_off);
    we_on = 4'(a_we_on);   we_off = 5'(a_we_off);
    oe_on = 4'(a_oe_on);   oe_off = 4'(a_oe_off);
    data_on = 4'(a_data_on); acc = 5'(a_acc);
    page = 4'(a_page);     cyc = 5'(a_cyc);
  endtask

  function automatic bit win(int c, int on, int off);
    return (c >= on) && (c < off);
  endfunction

  task automatic check_reset();
    chk({cs_n, adv_n, we_n, oe_n} == 4'hF, "R1 strobes", {cs_n, adv_n, we_n, oe_n}, 4'hF);
    chk(be_n == 2'b11 && ad == 16'h0, "R1 bus", {be_n, ad}, 18'h30000);
    chk(!dir && !done && !wready && !busy, "R1 ctl", {dir, done, wready, busy}, 0);
  endtask

  task automatic run_burst(input logic [26:0] a, input int len, input int stall_s,
                           input bit poke);
    int pe, f, base, total, got;
    pe = (page == 0) ? 1 : int'(page);
    f = pe * (len - 1);
    base = beats_total;
    total = int'(cyc) + f + stall_s;
    @(negedge clk);
    addr = a; blen = 3'(len - 1); start = 1'b1; wvalid = (stall_s == 0);
    @(posedge clk);
    @(negedge clk);
    start = 1'b0;
    for (int n = 1; n <= total + 1; n++) begin
      int k, c, beat;
      bit hold, frozen;
      logic [15:0] e_ad;
      logic [1:0] e_be;
      @(posedge clk);
      @(negedge clk);
      k = n - 1; hold = 0; frozen = 0; beat = 0;
      if (stall_s > 0 && k >= int'(data_on)) begin
        if (k < int'(data_on) + stall_s) hold = 1;
        else k = k - stall_s;
      end
      if (stall_s > 0 && n >= int'(data_on) && n <= int'(data_on) + stall_s)
        chk(wready == 1'b1, "R12 ready while stalled", wready, 1);
      if (!hold && k == int'(cyc) + f) begin
        chk(done == 1'b1, (len == 1) ? "R8 done time" : "R9 done time", done, 1);
        chk({cs_n, adv_n, we_n, oe_n} == 4'hF && !dir, "R9 idle at done",
            {cs_n, adv_n, we_n, oe_n, dir}, 5'h1E);
      end else begin
        if (hold) c = int'(data_on) - 1;
        else if (k <= int'(acc)) c = k;
        else if (k <= int'(acc) + f) begin
          c = int'(acc); frozen = 1; beat = 1 + (k - int'(acc) - 1) / pe;
        end else begin
          c = k - f; beat = len - 1;
        end
        if (c < int'(oe_off)) e_ad = {5'b0, a[26:16]};
        else if (c < int'(data_on)) e_ad = a[15:0];
        else e_ad = word_fn(base + beat);
        e_be = (c >= int'(data_on)) ? ~strb_fn(base + beat) : 2'b11;
        chk(cs_n == !win(c, cs_on, cs_off), frozen ? "R7 cs frozen" : "R2 cs", cs_n, !win(c, cs_on, cs_off));
        chk(adv_n == !win(c, adv_on, adv_off), "R3 adv", adv_n, !win(c, adv_on, adv_off));
        chk(we_n == !win(c, we_on, we_off), "R4 we", we_n, !win(c, we_on, we_off));
        chk(oe_n == !win(c, oe_on, oe_off), "R5 oe", oe_n, !win(c, oe_on, oe_off));
        chk(ad == e_ad, frozen ? "R7 beat word" : (c < int'(data_on) ? "R5 address" : "R6 data"), ad, e_ad);
        chk(be_n == e_be, "R6 byte enables", be_n, e_be);
        chk(dir == 1'b1, "R10 dir", dir, 1);
        chk(done == 1'b0, "R9 no early done", done, 0);
      end
      if (stall_s > 0 && n == int'(data_on) + stall_s) wvalid = 1'b1;
      start = poke && (n == 3);
      if (poke) addr = 27'h5A5A5A5;
    end
    got = beats_total - base;
    chk(got == len, "R12 beat count", got, len);
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      chk(cs_n && !done && !busy, poke ? "R11 no second access" : "R1 idle after",
          {cs_n, done, busy}, 3'b100);
    end
  endtask

  task automatic t_burst4();
    set_tim(1, 14, 1, 5, 6, 13, 1, 3, 6, 8, 3, 16);
    run_burst(27'h4ABCDEF, 4, 0, 0);
  endtask

  task automatic t_single();
    set_tim(0, 9, 0, 3, 3, 8, 0, 2, 4, 6, 2, 10);
    run_burst(27'h1234567, 1, 0, 0);
  endtask

  task automatic t_burst8_busy();
    set_tim(1, 14, 1, 5, 6, 13, 1, 3, 6, 8, 0, 16);
    run_burst(27'h7F0F0F0, 8, 0, 1);
  endtask

  task automatic t_stall();
    set_tim(1, 14, 1, 5, 6, 13, 1, 3, 6, 8, 2, 16);
    run_burst(27'h2468ACE, 2, 3, 0);
  endtask

  initial begin
    set_tim(0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0);
    #(CLK_PERIOD * 2 + 2);
    check_reset();
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check_reset();
    t_burst4();
    t_single();
    t_burst8_busy();
    t_stall();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 5000);
    wd_hit = 1'b1;
    errors++;
    checks++;
    $display("FAIL watchdog: actual=hung expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule